// File: doc/BRIEF.md
# Masked Pattern Match Monitor

This block watches a 64-bit stream of data beats, each qualified by a valid strobe. Every valid beat is tested against two masked patterns that software programs independently. A beat that matches the first pattern raises a timestamp request, but only while pattern timestamps are switched on. A beat that matches the second pattern raises a trigger pulse. Each mask bit decides whether the pattern bit at the same position takes part in the compare.

The block also chooses which beats go on to collection. In continuous mode it forwards every valid beat. In trace-on-change mode it forwards only beats that differ from the last beat it forwarded.

Software sets the block up through a single-cycle 32-bit register port. The port holds a control word, a timestamp enable word and eight pattern and mask words. Every output is registered and appears one clock after the beat that causes it.

Top module: `pmm_top`

## Requirements
- R1: After reset every register reads zero and trig_pulse, ts_req and coll_valid are low.
- R2: Registers read back what was written, with reg_rdata valid in the same cycle as reg_addr. The map is: 0xA00 control (bit0 enable, bit1 mode: 0 continuous, 1 trace-on-change), 0xA04 timestamp enable (bit0), 0xA08/0xA0C timestamp pattern, 0xA10/0xA14 timestamp mask, 0xA18/0xA1C trigger pattern, 0xA20/0xA24 trigger mask. In each pair the first word holds bits 31:0 and the second holds bits 63:32. Any other offset, including a misaligned one, reads zero.
- R3: trig_pulse is high for one cycle, in the cycle after each valid beat whose bits at mask-1 positions equal the trigger pattern. It stays low after a beat that does not match.
- R4: A mask bit of 0 makes that bit a don't-care, so an all-zero mask matches every valid beat.
- R5: ts_req pulses in the cycle after a valid beat that matches the timestamp pattern, and only when bit0 of the timestamp enable register is 1.
- R6: While beat_valid is low, no trigger, timestamp request or collected beat is produced.
- R7: In continuous mode every valid beat is forwarded: coll_valid is high the next cycle and coll_data equals that beat.
- R8: In trace-on-change mode a valid beat is forwarded only when it differs from the last forwarded beat. The first beat after enable is always forwarded.
- R9: While enable is 0 no output fires, and the change history is cleared. After re-enable, a beat equal to the previously forwarded one is forwarded again.
- R10: Trigger and timestamp matches are independent, so both pulses can fire in the same cycle for one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, single cycle |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| beat_valid | input | 1 | Data beat qualifier |
| beat_data | input | 64 | Data beat |
| trig_pulse | output | 1 | Trigger pattern matched on the previous beat |
| ts_req | output | 1 | Timestamp request for the previous beat |
| coll_valid | output | 1 | Previous beat forwarded for collection |
| coll_data | output | 64 | Forwarded beat |

## Verification
The trigger comparator and the timestamp comparator can both fire for the same beat. A collection pulse usually comes with them as well. The bench provokes this by programming the timestamp mask to zero, so every beat matches, and by enabling timestamps while the trigger pattern matches only on its upper word. A beat that carries the trigger word must then show trig_pulse, ts_req and coll_valid together in the next cycle. A beat without the trigger word must show ts_req alone, with no trigger pulse. Each of the three outputs is judged against its own scoreboard field for that cycle.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  localparam int ADDR_W     = 12;
  localparam int REG_W      = 32;
  localparam int BEAT_W     = 64;
  localparam int NWORD      = BEAT_W / REG_W;
  localparam int NPAT_WORDS = 4 * NWORD;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'hA00;
  localparam logic [ADDR_W-1:0] OFS_TSEN  = 12'hA04;
  localparam logic [ADDR_W-1:0] OFS_WORD0 = 12'hA08;

  // word groups in address order: ts pattern, ts mask, trig pattern, trig mask
  typedef struct packed {
    logic              en;
    logic              toc;
    logic              ts_en;
    logic [BEAT_W-1:0] ts_pat;
    logic [BEAT_W-1:0] ts_msk;
    logic [BEAT_W-1:0] tr_pat;
    logic [BEAT_W-1:0] tr_msk;
  } cfg_t;
endpackage

// File: rtl/pmm_cfg_regs.sv
module pmm_cfg_regs
  import pmm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output cfg_t              cfg
);
  logic [1:0] ctrl_q, ctrl_d;
  logic       tsen_q, tsen_d;
  logic       ctrl_we, tsen_we;
  logic [NPAT_WORDS-1:0][REG_W-1:0] words;

  always_comb begin
    ctrl_we = reg_wr && (reg_addr == OFS_CTRL);
    tsen_we = reg_wr && (reg_addr == OFS_TSEN);
    ctrl_d  = reg_wdata[1:0];
    tsen_d  = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tsen_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (tsen_we) tsen_q <= tsen_d;
    end
  end

  for (genvar i = 0; i < NPAT_WORDS; i++) begin : g_word
    localparam logic [ADDR_W-1:0] W_ADDR = OFS_WORD0 + ADDR_W'(4 * i);
    logic             we;
    logic [REG_W-1:0] q;
    assign we = reg_wr && (reg_addr == W_ADDR);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= reg_wdata;
    end
    assign words[i] = q;
  end

  always_comb begin
    cfg.en    = ctrl_q[0];
    cfg.toc   = ctrl_q[1];
    cfg.ts_en = tsen_q;
    for (int k = 0; k < NWORD; k++) begin
      cfg.ts_pat[k*REG_W +: REG_W] = words[0*NWORD + k];
      cfg.ts_msk[k*REG_W +: REG_W] = words[1*NWORD + k];
      cfg.tr_pat[k*REG_W +: REG_W] = words[2*NWORD + k];
      cfg.tr_msk[k*REG_W +: REG_W] = words[3*NWORD + k];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CTRL) reg_rdata[1:0] = ctrl_q;
    if (reg_addr == OFS_TSEN) reg_rdata[0]   = tsen_q;
    for (int i = 0; i < NPAT_WORDS; i++)
      if (reg_addr == OFS_WORD0 + ADDR_W'(4 * i)) reg_rdata = words[i];
  end
endmodule

// File: rtl/pmm_pulse_match.sv
module pmm_pulse_match #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic [W-1:0] data,
  input  logic [W-1:0] pat,
  input  logic [W-1:0] msk,
  output logic         pulse
);
  logic hit, pulse_d;

  always_comb begin
    hit     = ~|((data ^ pat) & msk);
    pulse_d = arm & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= pulse_d;
  end
endmodule

// File: rtl/pmm_change_filter.sv
module pmm_change_filter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         toc,
  input  logic         valid,
  input  logic [W-1:0] data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic         hist_q, hist_d;
  logic [W-1:0] last_q;
  logic         fwd;

  always_comb begin
    fwd    = en & valid & (~toc | ~hist_q | (data != last_q));
    hist_d = en ? (hist_q | fwd) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q    <= 1'b0;
      last_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      hist_q    <= hist_d;
      out_valid <= fwd;
      if (fwd) begin
        last_q   <= data;
        out_data <= data;
      end
    end
  end
endmodule

// File: rtl/pmm_top.sv
module pmm_top
  import pmm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              beat_valid,
  input  logic [BEAT_W-1:0] beat_data,
  output logic              trig_pulse,
  output logic              ts_req,
  output logic              coll_valid,
  output logic [BEAT_W-1:0] coll_data
);
  cfg_t cfg;
  logic cfg_en, cfg_tsen, arm_tr, arm_ts;

  pmm_cfg_regs u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .cfg
  );

  always_comb begin
    cfg_en   = cfg.en;
    cfg_tsen = cfg.ts_en;
    arm_tr   = cfg_en & beat_valid;
    arm_ts   = arm_tr & cfg_tsen;
  end

  pmm_pulse_match #(.W(BEAT_W)) u_trig (
    .clk, .rst_n, .arm(arm_tr), .data(beat_data),
    .pat(cfg.tr_pat), .msk(cfg.tr_msk), .pulse(trig_pulse)
  );

  pmm_pulse_match #(.W(BEAT_W)) u_tstamp (
    .clk, .rst_n, .arm(arm_ts), .data(beat_data),
    .pat(cfg.ts_pat), .msk(cfg.ts_msk), .pulse(ts_req)
  );

  pmm_change_filter #(.W(BEAT_W)) u_coll (
    .clk, .rst_n, .en(cfg_en), .toc(cfg.toc), .valid(beat_valid),
    .data(beat_data), .out_valid(coll_valid), .out_data(coll_data)
  );
endmodule

module pmm_checker
  import pmm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              beat_valid,
  input logic [BEAT_W-1:0] beat_data,
  input logic              cfg_en,
  input logic              cfg_tsen,
  input logic              trig_pulse,
  input logic              ts_req,
  input logic              coll_valid,
  input logic [BEAT_W-1:0] coll_data
);
  AST_TRIG_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(beat_valid)); // R3
  AST_TS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ts_req |-> ($past(cfg_tsen) && $past(beat_valid))); // R5
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(beat_valid) |-> !(trig_pulse || ts_req || coll_valid)); // R6
  AST_COLL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    coll_valid |-> (coll_data == $past(beat_data))); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_en) |-> !(trig_pulse || ts_req || coll_valid)); // R9
endmodule

bind pmm_top pmm_checker u_chk (
  .clk, .rst_n, .beat_valid, .beat_data, .cfg_en, .cfg_tsen,
  .trig_pulse, .ts_req, .coll_valid, .coll_data
);

// File: tb/sim_pmm_top.sv
module sim_pmm_top;
  localparam int PERIOD = 10;

  logic        clk, rst_n, reg_wr, beat_valid;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [63:0] beat_data, coll_data;
  logic        trig_pulse, ts_req, coll_valid;

  pmm_top u0 (.*);

  typedef struct {
    logic        tr, ts, cv;
    logic [63:0] cd;
    string       tag;
  } exp_t;
  exp_t q[$];

  int nchk = 0, nfail = 0;
  logic [31:0] sh_ctrl = 0, sh_tsen = 0;
  logic [31:0] sh_w [8];
  logic        hv = 0;
  logic [63:0] last = 0;

  initial clk = 0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push_idle(string tag);
    exp_t e;
    e.tr = 0; e.ts = 0; e.cv = 0; e.cd = '0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; beat_valid = 0;
    push_idle("R2");
    if (a == 12'hA00) begin sh_ctrl = d; if (!d[0]) hv = 0; end
    if (a == 12'hA04) sh_tsen = d;
    for (int i = 0; i < 8; i++) if (a == 12'hA08 + 12'(4*i)) sh_w[i] = d;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_wr = 0; reg_addr = a; beat_valid = 0;
    push_idle(tag);
    #1 chk(tag, "rdata", 64'(reg_rdata), 64'(exp));
  endtask

  task automatic beat(logic v, logic [63:0] d, string tag);
    exp_t e;
    logic en, toc;
    logic [63:0] tp, tm, xp, xm;
    @(negedge clk);
    reg_wr = 0; beat_valid = v; beat_data = d;
    en = sh_ctrl[0]; toc = sh_ctrl[1];
    tp = {sh_w[1], sh_w[0]}; tm = {sh_w[3], sh_w[2]};
    xp = {sh_w[5], sh_w[4]}; xm = {sh_w[7], sh_w[6]};
    if (!en) hv = 0;
    e.tag = tag;
    e.tr = en && v && (((d ^ xp) & xm) == 0);
    e.ts = en && v && sh_tsen[0] && (((d ^ tp) & tm) == 0);
    e.cv = en && v && (!toc || !hv || d != last);
    e.cd = d;
    if (e.cv) begin hv = 1; last = d; end
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_wr = 0; beat_valid = 0;
      push_idle("R6");
    end
  endtask

  // monitor: pops one expectation per cycle after the capturing edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, "trig_pulse", 64'(trig_pulse), 64'(e.tr));
        chk(e.tag, "ts_req", 64'(ts_req), 64'(e.ts));
        chk(e.tag, "coll_valid", 64'(coll_valid), 64'(e.cv));
        if (e.cv) chk(e.tag, "coll_data", coll_data, e.cd);
      end
    end
  end

  initial begin
    #(PERIOD * 50000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  localparam logic [63:0] BA = 64'h12345678_00000001;
  localparam logic [63:0] BB = 64'h12345679_9ABCDEF0;
  localparam logic [63:0] BC = 64'h0000_1111_2222_3333;
  localparam logic [63:0] BD = 64'h0000_1111_2222_3334;

  initial begin
    for (int i = 0; i < 8; i++) sh_w[i] = '0;
    rst_n = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    beat_valid = 0; beat_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state of outputs and registers
    chk("R1", "trig_pulse", 64'(trig_pulse), 0);
    chk("R1", "coll_valid", 64'(coll_valid), 0);
    rd(12'hA00, 0, "R1");
    rd(12'hA04, 0, "R1");
    for (int i = 0; i < 8; i++) rd(12'hA08 + 12'(4*i), 0, "R1");

    // R2: program and read back; upper word of a pair holds bits 63:32
    wr(12'hA18, 32'h9ABCDEF0);
    wr(12'hA1C, 32'h12345678);
    wr(12'hA20, 32'h0);
    wr(12'hA24, 32'hFFFFFFFF);
    wr(12'hA08, 32'hDEADBEEF);
    wr(12'hA00, 32'h1);
    rd(12'hA18, 32'h9ABCDEF0, "R2");
    rd(12'hA1C, 32'h12345678, "R2");
    rd(12'hA24, 32'hFFFFFFFF, "R2");
    rd(12'hA08, 32'hDEADBEEF, "R2");
    rd(12'hA00, 32'h1, "R2");
    rd(12'hA28, 32'h0, "R2");
    rd(12'hA1A, 32'h0, "R2");

    // R3/R5/R7: trigger on upper word only, timestamps off, continuous
    beat(1, BA, "R3");
    beat(1, BB, "R3");
    beat(1, BA, "R7");
    beat(0, BA, "R6");
    idle(1);

    // R4/R10: zero timestamp mask matches all beats
    wr(12'hA04, 32'h1);
    rd(12'hA04, 32'h1, "R2");
    beat(1, BA, "R10");
    beat(1, BB, "R4");
    idle(1);

    // R8: trace-on-change
    wr(12'hA00, 32'h3);
    beat(1, BC, "R8");
    beat(1, BC, "R8");
    beat(1, BC, "R8");
    beat(1, BD, "R8");
    beat(1, BC, "R8");
    idle(1);

    // R9: disabled, then re-enabled history
    wr(12'hA00, 32'h2);
    beat(1, BA, "R9");
    beat(1, BC, "R9");
    wr(12'hA00, 32'h3);
    beat(1, BC, "R9");
    beat(1, BC, "R8");
    idle(3);
    wait (q.size() == 0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule